// File: doc/BRIEF.md
# Hit Word Serial Link Transmitter

This block takes 24-bit hit words from a time-to-digital converter and sends them over one serial bit stream. Words arrive on a valid/ready handshake and are first written into a derandomizing FIFO. The FIFO absorbs bursts of hits that come in faster than the link can carry them. Each word leaves the FIFO as a frame of four 10-bit symbols: a K28.5 comma, then the three data bytes, highest byte first. Every byte is 8b/10b coded, and the running disparity carries across all symbols. When nothing is queued, the link sends K28.5 without a break, so a receiver stays aligned at all times.

Everything runs on a single clock, `clk`. The `bit_en` strobe marks each serial bit period. Ten strobes make one symbol period, so when `bit_en` is held high on a 400 MHz clock the link runs at 400 Mbit/s, which is 40 M symbols per second. Symbol boundaries are fixed from reset onward. The FIFO fill level, full, empty and a sticky overflow flag are brought out as status.

Top module: `hit_link_tx`

## Requirements
- R1: The FIFO holds up to DEPTH words (default 64). `in_ready` is low exactly when `fifo_level` equals DEPTH. `fifo_level` goes up by one for each accepted word and down by one for each word taken for transmission.
- R2: When `in_valid` is high while the FIFO is full, the word is dropped, `fifo_level` does not rise, and `overflow` goes high. `overflow` then stays high until reset.
- R3: Every accepted word is transmitted exactly once, in the order it was accepted.
- R4: A word is sent as a K28.5 symbol followed by data symbols for bits [23:16], [15:8] and [7:0], in that order. No comma appears inside these four symbols, and no data symbol appears other than directly after a frame comma.
- R5: While no word is queued, the stream carries only K28.5 symbols, back to back.
- R6: Symbols are 8b/10b coded. The running disparity starts negative after reset. Each data byte is split into a 5-bit part (bits [4:0]) coded to 6 bits and a 3-bit part (bits [7:5]) coded to 4 bits, and each part uses the form required by the current disparity. The alternate x.7 code is used for x = 17, 18, 20 at negative disparity and for x = 11, 13, 14 at positive disparity. K28.5 is 0011111010 at negative disparity and its complement at positive disparity. No run of equal bits on the line is longer than five.
- R7: Symbol bits leave in the order a, b, c, d, e, i, f, g, h, j. `ser_out` moves to the next bit on each clock with `bit_en` high and holds its value otherwise.
- R8: After reset, `ser_out` is 0, `fifo_level` is 0, `fifo_empty` is 1, `fifo_full` is 0, `in_ready` is 1 and `overflow` is 0. The first `bit_en` puts bit a of the first symbol on `ser_out`, and that first symbol is K28.5 in its negative-disparity form.
- R9: Each symbol lasts exactly ten `bit_en` pulses, and symbol boundaries fall every ten pulses counted from reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | Serial bit strobe; one output bit per high cycle |
| in_valid | input | 1 | Hit word offered |
| in_word | input | WORD_W (24) | Hit word |
| in_ready | output | 1 | FIFO can take a word |
| ser_out | output | 1 | Serial line bit |
| fifo_level | output | clog2(DEPTH+1) (7) | Words held in the FIFO |
| fifo_full | output | 1 | FIFO holds DEPTH words |
| fifo_empty | output | 1 | FIFO holds no words |
| overflow | output | 1 | Sticky flag: a word was offered while the FIFO was full |

## Verification
The assertions assume that `rst_n` is asserted before the first edge, and that `in_word` may take any value while `in_valid` is high, including values that the FIFO will drop. They also assume `bit_en` is an arbitrary strobe, with no minimum spacing and no alignment to words. The stimulus keeps within these assumptions and also exercises their edges: `bit_en` is driven always on, in a three-in-four pattern, and held off for long stretches, and the FIFO is filled while the line is frozen so that an overflow attempt meets a full queue. Data values are chosen to reach the D.x.7 alternate codes, the balanced D.07 and D.x.3 codes, and bytes that equal the comma's code value.

// File: rtl/hwtx_pkg.sv
package hwtx_pkg;

  localparam int SYM_W = 10;

  // K28.5, negative-disparity form, bit 0 = a (line order a..j = 0011111010)
  localparam logic [SYM_W-1:0] K_NEG_SYM = 10'b0101111100;

  typedef struct packed {
    logic [SYM_W-1:0] sym;  // bit 0 leaves first
    logic             rd;   // 1 = positive running disparity afterwards
  } enc_out_t;

  typedef enum logic {FR_COMMA, FR_DATA} fr_state_t;

  // 5b/6b code, negative-disparity column, MSB = a, LSB = i
  function automatic logic [5:0] code6(input logic [4:0] x);
    logic [5:0] c;
    case (x)
      5'd0:  c = 6'b100111;
      5'd1:  c = 6'b011101;
      5'd2:  c = 6'b101101;
      5'd3:  c = 6'b110001;
      5'd4:  c = 6'b110101;
      5'd5:  c = 6'b101001;
      5'd6:  c = 6'b011001;
      5'd7:  c = 6'b111000;
      5'd8:  c = 6'b111001;
      5'd9:  c = 6'b100101;
      5'd10: c = 6'b010101;
      5'd11: c = 6'b110100;
      5'd12: c = 6'b001101;
      5'd13: c = 6'b101100;
      5'd14: c = 6'b011100;
      5'd15: c = 6'b010111;
      5'd16: c = 6'b011011;
      5'd17: c = 6'b100011;
      5'd18: c = 6'b010011;
      5'd19: c = 6'b110010;
      5'd20: c = 6'b001011;
      5'd21: c = 6'b101010;
      5'd22: c = 6'b011010;
      5'd23: c = 6'b111010;
      5'd24: c = 6'b110011;
      5'd25: c = 6'b100110;
      5'd26: c = 6'b010110;
      5'd27: c = 6'b110110;
      5'd28: c = 6'b001110;
      5'd29: c = 6'b101110;
      5'd30: c = 6'b011110;
      default: c = 6'b101011;
    endcase
    return c;
  endfunction

  // 3b/4b code, negative-disparity column, MSB = f, LSB = j (primary x.7)
  function automatic logic [3:0] code4(input logic [2:0] y);
    logic [3:0] c;
    case (y)
      3'd0: c = 4'b1011;
      3'd1: c = 4'b1001;
      3'd2: c = 4'b0101;
      3'd3: c = 4'b1100;
      3'd4: c = 4'b1101;
      3'd5: c = 4'b1010;
      3'd6: c = 4'b0110;
      default: c = 4'b1110;
    endcase
    return c;
  endfunction

  // Whether x.7 must take the alternate form to avoid a run of six
  function automatic logic use_alt7(input logic [4:0] x, input logic rd6);
    logic a;
    if (rd6) a = (x == 5'd11) || (x == 5'd13) || (x == 5'd14);
    else     a = (x == 5'd17) || (x == 5'd18) || (x == 5'd20);
    return a;
  endfunction

  // Full symbol coder: data byte or K28.5, given the running disparity
  function automatic enc_out_t encode(input logic [7:0] d, input logic is_k,
                                      input logic rd);
    enc_out_t   r;
    logic [5:0] c6;
    logic [3:0] c4;
    logic       bal6, bal4, rd6;
    logic [9:0] nat;
    if (is_k) begin
      r.sym = rd ? ~K_NEG_SYM : K_NEG_SYM;
      r.rd  = ~rd;
    end else begin
      c6   = code6(d[4:0]);
      bal6 = ($countones(c6) == 3);
      if (rd && (!bal6 || d[4:0] == 5'd7)) c6 = ~c6;
      rd6  = bal6 ? rd : ~rd;
      c4   = code4(d[7:5]);
      if (d[7:5] == 3'd7 && use_alt7(d[4:0], rd6)) c4 = 4'b0111;
      bal4 = ($countones(c4) == 2);
      if (rd6 && (!bal4 || d[7:5] == 3'd3)) c4 = ~c4;
      nat  = {c6, c4};
      for (int k = 0; k < SYM_W; k++) r.sym[k] = nat[SYM_W-1-k];
      r.rd = bal4 ? rd6 : ~rd6;
    end
    return r;
  endfunction

endpackage

// File: rtl/hwtx_fifo.sv
module hwtx_fifo #(
  parameter int WIDTH = 24,
  parameter int DEPTH = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic [WIDTH-1:0]           in_data,
  output logic                       in_ready,
  input  logic                       pop,
  output logic [WIDTH-1:0]           rd_data,
  output logic                       empty,
  output logic                       full,
  output logic [$clog2(DEPTH+1)-1:0] level,
  output logic                       overflow
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] CAP    = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_A = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic [CW-1:0]    cnt;
  logic             push;
  logic             drop;

  assign full     = (cnt == CAP);
  assign empty    = (cnt == '0);
  assign in_ready = ~full;
  assign push     = in_valid && !full;
  assign drop     = in_valid && full;
  assign rd_data  = mem[rptr];
  assign level    = cnt;

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr     <= '0;
      rptr     <= '0;
      cnt      <= '0;
      overflow <= 1'b0;
    end else begin
      if (push) wptr <= (wptr == LAST_A) ? '0 : wptr + 1'b1;
      if (pop)  rptr <= (rptr == LAST_A) ? '0 : rptr + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
      if (drop) overflow <= 1'b1;
    end
  end

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CAP);  // R1
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);  // R2
  AST_DROP_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && full && !pop) |=> (level == $past(level) && overflow));  // R2
  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);  // R3

endmodule

// File: rtl/hwtx_framer.sv
module hwtx_framer
  import hwtx_pkg::*;
#(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sym_req,
  input  logic              empty,
  input  logic [WORD_W-1:0] rd_data,
  output logic              pop,
  output logic [7:0]        byte_out,
  output logic              is_k
);
  localparam int BYTES = WORD_W / 8;
  localparam int IW    = (BYTES > 1) ? $clog2(BYTES) : 1;
  localparam logic [IW-1:0] FIRST_IDX = IW'(BYTES - 1);

  fr_state_t         state;
  logic [WORD_W-1:0] hold;
  logic [IW-1:0]     idx;
  logic              last_byte;

  assign is_k      = (state == FR_COMMA);
  assign byte_out  = hold[WORD_W-1 -: 8];
  assign pop       = sym_req && (state == FR_COMMA) && !empty;
  assign last_byte = (idx == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= FR_COMMA;
      hold  <= '0;
      idx   <= '0;
    end else if (sym_req) begin
      case (state)
        FR_COMMA: begin
          if (!empty) begin
            hold  <= rd_data;
            idx   <= FIRST_IDX;
            state <= FR_DATA;
          end
        end
        default: begin
          hold <= hold << 8;
          if (last_byte) state <= FR_COMMA;
          else           idx   <= idx - 1'b1;
        end
      endcase
    end
  end

  AST_WORD_START: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> (state == FR_DATA && idx == FIRST_IDX));  // R4
  AST_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_req && state == FR_DATA && last_byte) |=> (state == FR_COMMA));  // R4

endmodule

// File: rtl/hwtx_encoder.sv
module hwtx_encoder
  import hwtx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sym_req,
  input  logic [7:0]       byte_in,
  input  logic             is_k,
  output logic [SYM_W-1:0] sym
);
  logic     rd_q;   // 0 = negative running disparity
  enc_out_t res;

  assign res = encode(byte_in, is_k, rd_q);
  assign sym = res.sym;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rd_q <= 1'b0;
    else if (sym_req) rd_q <= res.rd;
  end

  AST_K_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_req && is_k) |-> (sym == K_NEG_SYM || sym == ~K_NEG_SYM));  // R5
  AST_SYM_WEIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    sym_req |-> ($countones(sym) >= 4 && $countones(sym) <= 6));  // R6
  AST_RD_BIAS: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_req && !rd_q) |-> ($countones(sym) >= 5));  // R6
  AST_RD_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_req && $countones(sym) != 5) |=> (rd_q != $past(rd_q)));  // R6

endmodule

// File: rtl/hwtx_serializer.sv
module hwtx_serializer
  import hwtx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic [SYM_W-1:0] sym,
  output logic             sym_req,
  output logic             ser_out
);
  localparam int CNT_W = $clog2(SYM_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SYM_W - 1);

  logic [CNT_W-1:0] cnt;
  logic [SYM_W-1:0] sh;

  assign sym_req = bit_en && (cnt == LAST);
  assign ser_out = sh[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= LAST;
      sh  <= '0;
    end else if (sym_req) begin
      cnt <= '0;
      sh  <= sym;
    end else if (bit_en) begin
      cnt <= cnt + 1'b1;
      sh  <= sh >> 1;
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);  // R9
  AST_HOLD_NO_EN: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(ser_out));  // R7

endmodule

// File: rtl/hit_link_tx.sv
module hit_link_tx
  import hwtx_pkg::*;
#(
  parameter int WORD_W = 24,
  parameter int DEPTH  = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bit_en,
  input  logic                       in_valid,
  input  logic [WORD_W-1:0]          in_word,
  output logic                       in_ready,
  output logic                       ser_out,
  output logic [$clog2(DEPTH+1)-1:0] fifo_level,
  output logic                       fifo_full,
  output logic                       fifo_empty,
  output logic                       overflow
);
  logic              sym_req;
  logic              pop;
  logic [WORD_W-1:0] head_word;
  logic [7:0]        cur_byte;
  logic              cur_k;
  logic [SYM_W-1:0]  cur_sym;

  hwtx_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_data  (in_word),
    .in_ready (in_ready),
    .pop      (pop),
    .rd_data  (head_word),
    .empty    (fifo_empty),
    .full     (fifo_full),
    .level    (fifo_level),
    .overflow (overflow)
  );

  hwtx_framer #(.WORD_W(WORD_W)) u_framer (
    .clk      (clk),
    .rst_n    (rst_n),
    .sym_req  (sym_req),
    .empty    (fifo_empty),
    .rd_data  (head_word),
    .pop      (pop),
    .byte_out (cur_byte),
    .is_k     (cur_k)
  );

  hwtx_encoder u_enc (
    .clk     (clk),
    .rst_n   (rst_n),
    .sym_req (sym_req),
    .byte_in (cur_byte),
    .is_k    (cur_k),
    .sym     (cur_sym)
  );

  hwtx_serializer u_ser (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_en  (bit_en),
    .sym     (cur_sym),
    .sym_req (sym_req),
    .ser_out (ser_out)
  );

  AST_READY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready != fifo_full);  // R1

endmodule

// File: tb/hit_link_tx_tb.sv
module hit_link_tx_tb;
  localparam int WORD_W = 24;
  localparam int DEPTH  = 64;
  localparam int WD_CYC = 150000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bit_en;
  logic        in_valid;
  logic [23:0] in_word;
  logic        in_ready;
  logic        ser_out;
  logic [6:0]  fifo_level;
  logic        fifo_full;
  logic        fifo_empty;
  logic        overflow;

  always #10 clk = ~clk;  // 50 MHz

  hit_link_tx #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .in_valid(in_valid),
    .in_word(in_word), .in_ready(in_ready), .ser_out(ser_out),
    .fifo_level(fifo_level), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
    .overflow(overflow)
  );

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;
  int en_mode = 0;   // 0 off, 1 always, 2 three of four
  int pat = 0;
  logic [23:0] exp_q[$];

  // stream receiver state
  logic [9:0] rx_sym;
  int  nbits, run, fr, commas, words_rx;
  logic rd, last_b, have_bit, first_sym;
  logic [23:0] rx_word;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, expv);
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
  endtask

  // independent view of the code tables, written as line-order strings
  function automatic string t6(input int v);
    case (v)
      0: return "100111";  1: return "011101";  2: return "101101";  3: return "110001";
      4: return "110101";  5: return "101001";  6: return "011001";  7: return "111000";
      8: return "111001";  9: return "100101"; 10: return "010101"; 11: return "110100";
     12: return "001101"; 13: return "101100"; 14: return "011100"; 15: return "010111";
     16: return "011011"; 17: return "100011"; 18: return "010011"; 19: return "110010";
     20: return "001011"; 21: return "101010"; 22: return "011010"; 23: return "111010";
     24: return "110011"; 25: return "100110"; 26: return "010110"; 27: return "110110";
     28: return "001110"; 29: return "101110"; 30: return "011110"; default: return "101011";
    endcase
  endfunction

  function automatic string t4(input int y);
    case (y)
      0: return "1011"; 1: return "1001"; 2: return "0101"; 3: return "1100";
      4: return "1101"; 5: return "1010"; 6: return "0110"; default: return "1110";
    endcase
  endfunction

  // string char k -> bit k (first line bit at bit 0)
  function automatic logic [9:0] sbits(input string s);
    logic [9:0] r = '0;
    for (int k = 0; k < s.len(); k++) r[k] = (s[k] == 8'h31);
    return r;
  endfunction

  task automatic take_sym(input logic [9:0] s);
    logic [9:0] kn, kp;
    logic [5:0] c6, n6, e6;
    logic [3:0] c4, n4, e4;
    logic       f6, f4, rd6, bal, alt7, want7;
    int x, y;
    kn = sbits("0011111010");
    kp = ~kn;
    if (first_sym) begin
      chk(s == kn, "R8", "first symbol K28.5 negative form", s, kn);
      first_sym = 1'b0;
    end
    if (s == kn || s == kp) begin
      chk(s == (rd ? kp : kn), "R6", "comma disparity form", s, rd ? kp : kn);
      rd = ~rd;
      chk(fr < 2, "R4", "comma inside a word frame", fr, 1);
      fr = 1;
      commas++;
      return;
    end
    c6 = s[5:0];
    c4 = s[9:6];
    f6 = 1'b0; x = 0; rd6 = rd;
    for (int v = 0; v < 32; v++) begin
      n6  = sbits(t6(v))[5:0];
      bal = ($countones(n6) == 3);
      e6  = rd ? ((bal && v != 7) ? n6 : ~n6) : n6;
      if (!f6 && c6 == e6) begin
        f6 = 1'b1; x = v; rd6 = bal ? rd : ~rd;
      end
    end
    chk(f6, "R6", "6b sub-block legal for disparity", c6, 0);
    f4 = 1'b0; y = 0; alt7 = 1'b0;
    for (int v = 0; v < 7; v++) begin
      n4  = sbits(t4(v))[3:0];
      bal = ($countones(n4) == 2);
      e4  = rd6 ? ((bal && v != 3) ? n4 : ~n4) : n4;
      if (!f4 && c4 == e4) begin f4 = 1'b1; y = v; end
    end
    n4 = sbits("1110")[3:0];
    if (!f4 && c4 == (rd6 ? ~n4 : n4)) begin f4 = 1'b1; y = 7; end
    n4 = sbits("0111")[3:0];
    if (!f4 && c4 == (rd6 ? ~n4 : n4)) begin f4 = 1'b1; y = 7; alt7 = 1'b1; end
    chk(f4, "R6", "4b sub-block legal for disparity", c4, 0);
    if (y == 7) begin
      want7 = rd6 ? (x == 11 || x == 13 || x == 14) : (x == 17 || x == 18 || x == 20);
      chk(alt7 == want7, "R6", "alternate x.7 choice", alt7, want7);
    end
    rd = ($countones(c4) == 2) ? rd6 : ~rd6;
    case (fr)
      1: begin rx_word = {x[2:0] == 3'b0 ? 8'h0 : 8'h0, 16'h0}; rx_word[23:16] = {y[2:0], x[4:0]}; fr = 2; end
      2: begin rx_word[15:8] = {y[2:0], x[4:0]}; fr = 3; end
      3: begin
        rx_word[7:0] = {y[2:0], x[4:0]};
        fr = 0;
        words_rx++;
        chk(exp_q.size() > 0, "R5", "data while nothing queued", words_rx, 0);
        if (exp_q.size() > 0) begin
          chk(rx_word == exp_q[0], "R3", "word order and content", rx_word, exp_q[0]);
          void'(exp_q.pop_front());
        end
      end
      default: chk(1'b0, "R4", "data symbol without frame comma", s, 0);
    endcase
  endtask

  // stream monitor and bit strobe driver, every clock
  always @(negedge clk) begin
    if (!rst_n) begin
      nbits = 0; run = 0; fr = 0; commas = 0; words_rx = 0;
      rd = 1'b0; last_b = 1'b0; have_bit = 1'b0; first_sym = 1'b1;
      rx_sym = '0; bit_en = 1'b0; pat = 0;
    end else begin
      if (bit_en) begin
        if (have_bit && ser_out == last_b) run++;
        else run = 1;
        chk(run <= 5, "R6", "run length on line", run, 5);
        last_b = ser_out;
        have_bit = 1'b1;
        rx_sym[nbits] = ser_out;
        nbits++;
        if (nbits == 10) begin  // R9 boundary every ten strobes
          take_sym(rx_sym);
          nbits = 0;
        end
      end else if (have_bit) begin
        chk(ser_out == last_b, "R7", "line holds without strobe", ser_out, last_b);
      end
      pat++;
      case (en_mode)
        1:       bit_en = 1'b1;
        2:       bit_en = (pat % 4 != 3);
        default: bit_en = 1'b0;
      endcase
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == WD_CYC) begin
      chk(1'b0, "R3", "watchdog expired", cyc, 0);
      report();
      $finish;
    end
  end

  task automatic push(input logic [23:0] w, output bit acc);
    @(negedge clk);
    in_valid = 1'b1;
    in_word  = w;
    acc = in_ready;
    if (acc) exp_q.push_back(w);
  endtask

  task automatic drop_valid();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (exp_q.size() == 0 && fr != 2 && fr != 3) break;
    end
    repeat (50) @(negedge clk);
    chk(exp_q.size() == 0, "R3", "all accepted words delivered", exp_q.size(), 0);
  endtask

  initial begin
    bit acc;
    logic [23:0] singles[8];
    singles[0] = 24'hF1EBF4; singles[1] = 24'hEDEEF2; singles[2] = 24'h07E7FF;
    singles[3] = 24'hBCBC00; singles[4] = 24'h000000; singles[5] = 24'hFFFFFF;
    singles[6] = 24'hABCDEF; singles[7] = 24'h800001;
    rst_n = 1'b0; in_valid = 1'b0; in_word = '0; en_mode = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    chk(ser_out == 1'b0, "R8", "ser_out after reset", ser_out, 0);
    chk(fifo_level == 0, "R8", "level after reset", fifo_level, 0);
    chk(fifo_empty == 1'b1, "R8", "empty after reset", fifo_empty, 1);
    chk(fifo_full == 1'b0, "R8", "full after reset", fifo_full, 0);
    chk(in_ready == 1'b1, "R8", "ready after reset", in_ready, 1);
    chk(overflow == 1'b0, "R8", "overflow after reset", overflow, 0);

    // R5 idle commas
    en_mode = 1;
    repeat (200) @(negedge clk);
    chk(commas >= 15, "R5", "idle comma count", commas, 15);
    chk(words_rx == 0, "R5", "no words while idle", words_rx, 0);

    // single words, R3 R4 R6
    for (int i = 0; i < 8; i++) begin
      push(singles[i], acc);
      drop_valid();
      repeat (60) @(negedge clk);
    end
    drain();
    chk(words_rx == 8, "R4", "framed words received", words_rx, 8);

    // back-to-back burst, R3
    for (int i = 0; i < 20; i++) push(24'h5A3C00 ^ (i * 24'h010307), acc);
    drop_valid();
    drain();
    chk(words_rx == 28, "R3", "burst words received", words_rx, 28);

    // gapped bit strobe, R7
    en_mode = 2;
    for (int i = 0; i < 10; i++) begin
      push(24'h123456 + i * 24'h111111, acc);
      drop_valid();
    end
    drain();
    chk(words_rx == 38, "R7", "words through gapped strobe", words_rx, 38);

    // fill with line frozen, R1 R2
    en_mode = 0;
    repeat (30) @(negedge clk);
    chk(fifo_level == 0, "R1", "level empty before fill", fifo_level, 0);
    for (int i = 0; i < DEPTH; i++) begin
      push(24'hC00000 + i * 24'h000105, acc);
      chk(acc, "R1", "ready while room", acc, 1);
    end
    push(24'hDEAD01, acc);
    chk(fifo_level == 64, "R1", "level at capacity", fifo_level, 64);
    chk(in_ready == 1'b0 && fifo_full == 1'b1, "R1", "ready low when full",
        {in_ready, fifo_full}, 2'b01);
    chk(!acc, "R2", "word refused when full", acc, 0);
    drop_valid();
    chk(overflow == 1'b1, "R2", "overflow set", overflow, 1);
    chk(fifo_level == 64, "R2", "dropped word not counted", fifo_level, 64);
    en_mode = 1;
    drain();
    chk(words_rx == 38 + DEPTH, "R3", "full queue delivered in order",
        words_rx, 38 + DEPTH);
    chk(overflow == 1'b1, "R2", "overflow still set after drain", overflow, 1);
    chk(fifo_level == 0 && fifo_empty == 1'b1, "R1", "level back to zero",
        fifo_level, 0);
    report();
    $finish;
  end
endmodule